// File: doc/BRIEF.md
# Leading Zero and Leading One Counter

This unit takes a 32-bit operand and returns how many consecutive bits, starting at the most significant bit, equal zero or equal one. It serves the count-leading-bits functions of an extended arithmetic opcode group. The caller presents the operand, a 6-bit function code and a valid strobe. One clock later the unit presents the count, zero-extended to the full register width so it can be written straight to a destination register, with a matching valid flag.

The count comes from a staged halving search, not from a priority encoder. A running length starts at the word width. Each stage tests the upper half of the field it receives. When that half holds any set bit, the stage subtracts the half width from the length and passes the upper half on. Otherwise it passes the lower half on. The stages work on 16-, 8- and 4-bit fields. A 16-entry lookup of the last nibble's significant-bit count finishes the search. To count leading ones, the same logic runs on the complemented operand.

A two-state controller holds the output register. ST_IDLE means no fresh result is present. ST_VALID means the register holds a result captured on the previous edge. Both states move to ST_VALID on an accepted request and to ST_IDLE otherwise.

Top module: `lead_count_unit`

## Requirements
- R1: A zero operand with function code 32 gives a count of exactly 32.
- R2: Function code 33 gives the leading-zero count of the bitwise complement of the operand, so an all-ones operand gives 32 and a zero operand gives 0.
- R3: With function code 32, the count equals the number of zero bits above the highest set bit: 0 when bit 31 is set, 31 when only bit 0 is set.
- R4: Only function codes 32 (leading zeros) and 33 (leading ones) are accepted. A request with any other code raises no out_valid and leaves out_count unchanged.
- R5: out_valid is high in exactly the cycle after an accepted request (in_valid high with code 32 or 33), and out_count shows that request's result in the same cycle.
- R6: out_count bits 31 down to 6 are always zero, and the count never exceeds 32.
- R7: After reset, out_valid is 0 and out_count is 0.
- R8: In a cycle with no accepted request, out_count keeps its previous value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_func | input | 6 | Function code: 32 counts leading zeros, 33 counts leading ones |
| in_operand | input | 32 | Word to examine |
| out_valid | output | 1 | Result valid, one cycle after an accepted request |
| out_count | output | 32 | Leading-bit count, zero-extended |

## Verification
The bound checker checks on every cycle the timing that links a request to its result, the rejection of foreign function codes, the holding of the result register between requests, and the range and zero upper bits of the count. It also checks the two fixed answers of 32, one for a zero operand counted for zeros and one for an all-ones operand counted for ones. Whether every other count is numerically right can only be shown by the bench's scenarios. These include a table of hand-worked vectors and walks of a single set bit and a single clear bit across all 32 positions, compared against a simple bit-by-bit scan from the top.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam logic [5:0] FN_LEAD_ZERO = 6'd32;
    localparam logic [5:0] FN_LEAD_ONE  = 6'd33;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } lzc_state_e;
endpackage

// File: rtl/lzc_halve_stage.sv
// One step of the halving search: keep the upper half when it holds a set bit.
module lzc_halve_stage #(
    parameter int F  = 16,
    parameter int CW = 6
) (
    input  logic [2*F-1:0] val_i,
    input  logic [CW-1:0]  len_i,
    output logic [F-1:0]   val_o,
    output logic [CW-1:0]  len_o
);
    logic hit;

    always_comb begin
        hit   = |val_i[2*F-1:F];
        val_o = hit ? val_i[2*F-1:F] : val_i[F-1:0];
        len_o = hit ? (len_i - CW'(F)) : len_i;
    end
endmodule

// File: rtl/lzc_nibble_lut.sv
// Significant-bit count of a 4-bit field.
module lzc_nibble_lut (
    input  logic [3:0] nib_i,
    output logic [2:0] sig_o
);
    always_comb begin
        unique casez (nib_i)
            4'b1???: sig_o = 3'd4;
            4'b01??: sig_o = 3'd3;
            4'b001?: sig_o = 3'd2;
            4'b0001: sig_o = 3'd1;
            default: sig_o = 3'd0;
        endcase
    end
endmodule

// File: rtl/lzc_core.sv
// Combinational leading-bit count: optional inversion, halving stages, nibble lookup.
module lzc_core #(
    parameter int WIDTH = 32,
    parameter int CW    = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic             ones_i,
    output logic [CW-1:0]    count_o
);
    localparam int STAGES = $clog2(WIDTH) - 2;

    logic [WIDTH-1:0] src;
    logic [2:0]       nib_sig;

    assign src = ones_i ? ~operand_i : operand_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int F = WIDTH >> (g + 1);
        logic [2*F-1:0] val_in;
        logic [CW-1:0]  len_in;
        logic [F-1:0]   val_out;
        logic [CW-1:0]  len_out;

        if (g == 0) begin : g_first
            assign val_in = src;
            assign len_in = CW'(WIDTH);
        end else begin : g_next
            assign val_in = g_stage[g-1].val_out;
            assign len_in = g_stage[g-1].len_out;
        end

        lzc_halve_stage #(.F(F), .CW(CW)) u_stage (
            .val_i (val_in),
            .len_i (len_in),
            .val_o (val_out),
            .len_o (len_out)
        );
    end

    lzc_nibble_lut u_lut (
        .nib_i (g_stage[STAGES-1].val_out),
        .sig_o (nib_sig)
    );

    assign count_o = g_stage[STAGES-1].len_out - CW'(nib_sig);
endmodule

// File: rtl/lead_count_unit.sv
module lead_count_unit #(
    parameter int WIDTH = lzc_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       in_func,
    input  logic [WIDTH-1:0] in_operand,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_count
);
    import lzc_pkg::*;

    localparam int CW = $clog2(WIDTH) + 1;

    lzc_state_e    state_q, state_d;
    logic [CW-1:0] count_q;
    logic [CW-1:0] core_count;
    logic          code_ok;
    logic          accept;
    logic          want_ones;

    assign code_ok   = (in_func == FN_LEAD_ZERO) || (in_func == FN_LEAD_ONE);
    assign accept    = in_valid && code_ok;
    assign want_ones = (in_func == FN_LEAD_ONE);

    lzc_core #(.WIDTH(WIDTH), .CW(CW)) u_core (
        .operand_i (in_operand),
        .ones_i    (want_ones),
        .count_o   (core_count)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = accept ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (accept) count_q <= core_count;
    end

    assign out_valid = (state_q == ST_VALID);
    assign out_count = {{(WIDTH-CW){1'b0}}, count_q};
endmodule

// File: rtl/lead_count_unit_chk.sv
module lead_count_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [5:0]       in_func,
    input logic [WIDTH-1:0] in_operand,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_count
);
    localparam logic [5:0] FZ = 6'd32;
    localparam logic [5:0] FO = 6'd33;

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_func == FZ || in_func == FO)) |=> out_valid);

    assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (in_func == FZ || in_func == FO)) |=> !out_valid);

    assert_bad_code_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func != FZ && in_func != FO) |=> ($stable(out_count) && !out_valid));

    assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (in_func == FZ || in_func == FO)) |=> $stable(out_count));

    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count <= WIDTH'(WIDTH)));

    assert_zero_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == FZ && in_operand == '0) |=> (out_count == WIDTH'(WIDTH)));

    assert_ones_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == FO && in_operand == '1) |=> (out_count == WIDTH'(WIDTH)));
endmodule

bind lead_count_unit lead_count_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_func    (in_func),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_count  (out_count)
);

// File: tb/lead_count_unit_tb.sv
module lead_count_unit_tb;
    localparam int NV = 14;
    localparam logic [31:0] V_OP [NV] = '{
        32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h8000_0000, 32'h0000_0001, 32'h0000_FFFF, 32'h0001_0000,
        32'h7FFF_FFFF, 32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_FFFE,
        32'h0080_0000, 32'h0000_000F};
    localparam logic [5:0] V_FN [NV] = '{
        6'd32, 6'd33, 6'd33, 6'd32, 6'd32, 6'd32, 6'd32, 6'd32,
        6'd32, 6'd33, 6'd33, 6'd33, 6'd32, 6'd32};
    localparam logic [31:0] V_EXP [NV] = '{
        32, 0, 32, 0, 0, 31, 16, 15, 1, 4, 16, 31, 8, 28};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_func = 6'd32;
    logic [31:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lead_count_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_func    (in_func),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_count  (out_count)
    );

    function automatic logic [31:0] ref_lead(input logic [31:0] w, input logic ones);
        logic [31:0] n = 0;
        logic        run = 1'b1;
        for (int i = 31; i >= 0; i--) begin
            if (run && (w[i] == ones)) n++;
            else run = 1'b0;
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check the result at the next falling edge.
    task automatic apply(input logic [31:0] op, input logic [5:0] fn, input logic v,
                         input logic [31:0] exp_cnt, input logic exp_v, input string req);
        @(negedge clk);
        in_operand = op;
        in_func    = fn;
        in_valid   = v;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, {31'd0, exp_v});
        check({req, " count"}, out_count, exp_cnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 valid", {31'd0, out_valid}, 32'd0);
        check("R7 count", out_count, 32'd0);
        rst_n = 1'b1;

        // Table walk: R1, R2, R3, R5, R6
        for (int k = 0; k < NV; k++)
            apply(V_OP[k], V_FN[k], 1'b1, V_EXP[k], 1'b1, "R3/R2 table");

        // R1 zero word and R6 upper bits
        apply(32'h0, 6'd32, 1'b1, 32'd32, 1'b1, "R1 zero word");
        check("R6 upper bits", {26'd0, out_count[31:6]} , 32'd0);

        // R4: foreign function codes leave count and valid untouched
        apply(32'h0000_00FF, 6'd34, 1'b1, 32'd32, 1'b0, "R4 code 34");
        apply(32'h0000_00FF, 6'd0,  1'b1, 32'd32, 1'b0, "R4 code 0");
        apply(32'h0000_00FF, 6'd2,  1'b1, 32'd32, 1'b0, "R4 code 2");

        // R8: no request, count holds
        apply(32'h8000_0000, 6'd32, 1'b0, 32'd32, 1'b0, "R8 idle hold");
        @(negedge clk);
        check("R8 second idle", out_count, 32'd32);

        // R5: back-to-back requests, each result one cycle later
        @(negedge clk);
        in_valid = 1'b1; in_func = 6'd32; in_operand = 32'h0000_0100;
        @(negedge clk);
        check("R5 b2b first", out_count, 32'd23);
        check("R5 b2b valid", {31'd0, out_valid}, 32'd1);
        in_func = 6'd33; in_operand = 32'hFC00_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 b2b second", out_count, 32'd6);
        @(negedge clk);
        check("R5 valid drops", {31'd0, out_valid}, 32'd0);

        // R3: walking single one; R2: walking single zero
        for (int b = 0; b < 32; b++) begin
            apply(32'h1 << b, 6'd32, 1'b1, ref_lead(32'h1 << b, 1'b0), 1'b1, "R3 walk one");
            apply(~(32'h1 << b), 6'd33, 1'b1, ref_lead(~(32'h1 << b), 1'b1), 1'b1, "R2 walk zero");
        end

        // R7: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 re-reset count", out_count, 32'd0);
        check("R7 re-reset valid", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule